// File: doc/BRIEF.md
# Segment Register Load Checker

This block decides whether a descriptor may be placed into one of the six segment registers. The caller presents the target register, the selector (index, table bit, requested privilege), the current privilege level and the already decoded descriptor attributes in one cycle. One clock later the block returns a verdict: accept or reject, plus a cause code that says which rule failed.

The block works out the effective privilege level as the numerically larger of the current level and the selector's requested level. It then checks the selector for null, checks the descriptor type against the target register, and checks privilege. The type and privilege rules differ between the code register, the stack register and the four data registers. Presence is checked last. Fetching descriptors from memory lies outside the block.

Top module: `seg_load_chk`

## Requirements
- R1: The verdict (`rsp_valid`, `rsp_accept`, `rsp_cause`) is registered. `rsp_valid` is high exactly in the cycle after `req_valid` is sampled high. A synchronous active-high reset clears all three outputs to 0.
- R2: The effective privilege level is max(`cpl`, `sel_rpl`). With `sel_rpl`=3 and `cpl`=0, a data load with DPL 2 is refused. With `sel_rpl`=1 and `cpl`=2, the same load is allowed.
- R3: A selector is null when the index and the table bit are both zero, whatever the RPL. A null selector into CS (code 0) or SS (code 1) is rejected with cause 1.
- R4: A null selector into DS, ES, FS or GS (codes 2 to 5) is accepted with cause 0, whatever the descriptor attributes are.
- R5: CS accepts only a non-system code descriptor. Any other descriptor gives cause 2. CS applies no privilege rule.
- R6: DS, ES, FS and GS reject, with cause 2, system descriptors and code descriptors that are not readable. Data descriptors pass the type rule.
- R7: SS accepts only a non-system, non-code, writable descriptor. Any other descriptor gives cause 2.
- R8: A data-register load passes the privilege rule only when DPL >= EPL numerically. Otherwise it gives cause 3.
- R9: A readable conforming code descriptor loaded into a data register skips the privilege rule.
- R10: An SS load passes the privilege rule only when RPL == CPL and DPL == CPL. Otherwise it gives cause 3.
- R11: The not-present cause 4 is reported only when the null, type and privilege rules all pass. When several rules fail, the order of precedence is null, then type, then privilege, then present.
- R12: The cause encoding is 0 ok, 1 null, 2 type, 3 privilege, 4 not present. `rsp_accept` is high exactly when the cause is 0. Register codes 6 and 7 are reserved and are rejected with cause 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_reg | input | 3 | Target register: 0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS |
| sel_index | input | IDX_W | Selector table index |
| sel_ti | input | 1 | Selector table indicator |
| sel_rpl | input | PL_W | Selector requested privilege |
| cpl | input | PL_W | Current privilege level |
| d_sys | input | 1 | Descriptor is a system descriptor |
| d_code | input | 1 | Descriptor is code (else data) |
| d_rd | input | 1 | Code descriptor is readable |
| d_wr | input | 1 | Data descriptor is writable |
| d_conf | input | 1 | Code descriptor is conforming |
| d_dpl | input | PL_W | Descriptor privilege level |
| d_present | input | 1 | Descriptor present bit |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_accept | output | 1 | Load is allowed |
| rsp_cause | output | 3 | Cause code |

## Verification
Type failures and privilege failures can occur in the same request, often together with a cleared present bit. Examples are SS given a read-only data descriptor with a mismatched DPL, and a data register given an unreadable code descriptor whose DPL is too low. The bench drives such multi-fault requests and checks that the cause is the highest-precedence one. It also drives a null data-register selector whose descriptor attributes are all hostile, and checks that the load is still accepted.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam logic [2:0] REG_CS = 3'd0;
  localparam logic [2:0] REG_SS = 3'd1;
  localparam logic [2:0] REG_DS = 3'd2;
  localparam logic [2:0] REG_ES = 3'd3;
  localparam logic [2:0] REG_FS = 3'd4;
  localparam logic [2:0] REG_GS = 3'd5;

  localparam logic [2:0] CAUSE_OK   = 3'd0;
  localparam logic [2:0] CAUSE_NULL = 3'd1;
  localparam logic [2:0] CAUSE_TYPE = 3'd2;
  localparam logic [2:0] CAUSE_PRIV = 3'd3;
  localparam logic [2:0] CAUSE_NP   = 3'd4;

  typedef enum logic [1:0] {
    CLS_CODE  = 2'd0,
    CLS_STACK = 2'd1,
    CLS_DATA  = 2'd2,
    CLS_BAD   = 2'd3
  } reg_class_e;

  function automatic reg_class_e classify(input logic [2:0] r);
    case (r)
      REG_CS:                         classify = CLS_CODE;
      REG_SS:                         classify = CLS_STACK;
      REG_DS, REG_ES, REG_FS, REG_GS: classify = CLS_DATA;
      default:                        classify = CLS_BAD;
    endcase
  endfunction
endpackage

// File: rtl/seg_null_det.sv
module seg_null_det #(
  parameter int IDX_W = 13
) (
  input  logic [IDX_W-1:0] index,
  input  logic             ti,
  output logic             is_null
);
  always_comb is_null = (index == '0) && !ti;
endmodule

// File: rtl/seg_type_chk.sv
module seg_type_chk
  import seg_chk_pkg::*;
(
  input  reg_class_e cls,
  input  logic       d_sys,
  input  logic       d_code,
  input  logic       d_rd,
  input  logic       d_wr,
  output logic       type_ok
);
  always_comb begin
    unique case (cls)
      CLS_CODE:  type_ok = !d_sys && d_code;
      CLS_STACK: type_ok = !d_sys && !d_code && d_wr;
      CLS_DATA:  type_ok = !d_sys && (!d_code || d_rd);
      default:   type_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk
  import seg_chk_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  reg_class_e       cls,
  input  logic [PL_W-1:0]  rpl,
  input  logic [PL_W-1:0]  cpl,
  input  logic [PL_W-1:0]  dpl,
  input  logic             d_code,
  input  logic             d_rd,
  input  logic             d_conf,
  output logic [PL_W-1:0]  epl,
  output logic             priv_ok
);
  logic conf_skip;

  always_comb begin
    epl       = (rpl > cpl) ? rpl : cpl;
    conf_skip = d_code && d_conf && d_rd;
    unique case (cls)
      CLS_CODE:  priv_ok = 1'b1;
      CLS_STACK: priv_ok = (rpl == cpl) && (dpl == cpl);
      CLS_DATA:  priv_ok = conf_skip || (dpl >= epl);
      default:   priv_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
  import seg_chk_pkg::*;
#(
  parameter int IDX_W = 13,
  parameter int PL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_reg,
  input  logic [IDX_W-1:0] sel_index,
  input  logic             sel_ti,
  input  logic [PL_W-1:0]  sel_rpl,
  input  logic [PL_W-1:0]  cpl,
  input  logic             d_sys,
  input  logic             d_code,
  input  logic             d_rd,
  input  logic             d_wr,
  input  logic             d_conf,
  input  logic [PL_W-1:0]  d_dpl,
  input  logic             d_present,
  output logic             rsp_valid,
  output logic             rsp_accept,
  output logic [2:0]       rsp_cause
);
  reg_class_e      cls;
  logic            is_null, type_ok, priv_ok;
  logic [PL_W-1:0] epl;
  logic [2:0]      cause_nx;

  always_comb cls = classify(req_reg);

  seg_null_det #(.IDX_W(IDX_W)) u_null (
    .index(sel_index), .ti(sel_ti), .is_null(is_null)
  );

  seg_type_chk u_type (
    .cls(cls), .d_sys(d_sys), .d_code(d_code), .d_rd(d_rd), .d_wr(d_wr),
    .type_ok(type_ok)
  );

  seg_priv_chk #(.PL_W(PL_W)) u_priv (
    .cls(cls), .rpl(sel_rpl), .cpl(cpl), .dpl(d_dpl), .d_code(d_code),
    .d_rd(d_rd), .d_conf(d_conf), .epl(epl), .priv_ok(priv_ok)
  );

  // Precedence: null, type, privilege, present
  always_comb begin
    if (is_null && cls == CLS_DATA)      cause_nx = CAUSE_OK;
    else if (is_null && cls != CLS_BAD)  cause_nx = CAUSE_NULL;
    else if (!type_ok)                   cause_nx = CAUSE_TYPE;
    else if (!priv_ok)                   cause_nx = CAUSE_PRIV;
    else if (!d_present)                 cause_nx = CAUSE_NP;
    else                                 cause_nx = CAUSE_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_cause  <= CAUSE_OK;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cause  <= cause_nx;
        rsp_accept <= (cause_nx == CAUSE_OK);
      end
    end
  end
endmodule

// File: rtl/seg_load_chk_sva.sv
module seg_load_chk_sva #(
  parameter int IDX_W = 13,
  parameter int PL_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [2:0]       req_reg,
  input logic [IDX_W-1:0] sel_index,
  input logic             sel_ti,
  input logic [PL_W-1:0]  sel_rpl,
  input logic [PL_W-1:0]  cpl,
  input logic             d_sys,
  input logic             rsp_valid,
  input logic             rsp_accept,
  input logic [2:0]       rsp_cause
);
  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3
  null_cs_ss_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_reg <= 3'd1 && sel_index == '0 && !sel_ti)
      |=> (rsp_cause == 3'd1));
  // R4
  null_data_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_reg >= 3'd2 && req_reg <= 3'd5 && sel_index == '0 && !sel_ti)
      |=> rsp_accept);
  // R6
  data_sys_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_reg >= 3'd2 && req_reg <= 3'd5 && d_sys && (sel_index != '0 || sel_ti))
      |=> (rsp_cause == 3'd2));
  // R12
  accept_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_accept == (rsp_cause == 3'd0)) && (rsp_cause <= 3'd4));
endmodule

bind seg_load_chk seg_load_chk_sva #(.IDX_W(IDX_W), .PL_W(PL_W)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_reg(req_reg),
  .sel_index(sel_index), .sel_ti(sel_ti), .sel_rpl(sel_rpl), .cpl(cpl),
  .d_sys(d_sys), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
  .rsp_cause(rsp_cause)
);

// File: tb/sim_seg_load_chk.sv
module sim_seg_load_chk;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 13;
  localparam int PL_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_reg = '0;
  logic [IDX_W-1:0] sel_index = '0;
  logic sel_ti = 1'b0;
  logic [PL_W-1:0] sel_rpl = '0, cpl = '0, d_dpl = '0;
  logic d_sys = 1'b0, d_code = 1'b0, d_rd = 1'b0, d_wr = 1'b0, d_conf = 1'b0, d_present = 1'b0;
  logic rsp_valid, rsp_accept;
  logic [2:0] rsp_cause;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_load_chk #(.IDX_W(IDX_W), .PL_W(PL_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_reg(req_reg),
    .sel_index(sel_index), .sel_ti(sel_ti), .sel_rpl(sel_rpl), .cpl(cpl),
    .d_sys(d_sys), .d_code(d_code), .d_rd(d_rd), .d_wr(d_wr), .d_conf(d_conf),
    .d_dpl(d_dpl), .d_present(d_present),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_cause(rsp_cause)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One request; descriptor fields packed as {sys,code,rd,wr,conf,present}
  task automatic load(input string req, input logic [2:0] r, input logic [IDX_W-1:0] idx,
                      input logic ti, input logic [1:0] rpl, input logic [1:0] c,
                      input logic [5:0] attr, input logic [1:0] dpl, input logic [2:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_reg = r; sel_index = idx; sel_ti = ti;
    sel_rpl = rpl; cpl = c; d_dpl = dpl;
    {d_sys, d_code, d_rd, d_wr, d_conf, d_present} = attr;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {2'b0, rsp_valid}, 3'd1);
    check({req, " cause"}, rsp_cause, exp);
    check({req, " accept"}, {2'b0, rsp_accept}, {2'b0, exp == 3'd0});
  endtask

  // attribute shorthands: {sys,code,rd,wr,conf,present}
  localparam logic [5:0] A_DATA_RW = 6'b000101;
  localparam logic [5:0] A_DATA_RO = 6'b000001;
  localparam logic [5:0] A_CODE_X  = 6'b010001;
  localparam logic [5:0] A_CODE_R  = 6'b011001;
  localparam logic [5:0] A_CODE_RC = 6'b011011;
  localparam logic [5:0] A_SYS     = 6'b100001;

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset valid", {2'b0, rsp_valid}, 3'd0);
    check("R1 reset cause", rsp_cause, 3'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", {2'b0, rsp_valid}, 3'd0);
  endtask

  task automatic t_null();
    load("R3 null CS", 3'd0, '0, 1'b0, 2'd3, 2'd0, A_CODE_R, 2'd0, 3'd1);
    load("R3 null SS", 3'd1, '0, 1'b0, 2'd0, 2'd0, A_DATA_RW, 2'd0, 3'd1);
    load("R3 ti set not null", 3'd1, '0, 1'b1, 2'd0, 2'd0, A_DATA_RW, 2'd0, 3'd0);
    load("R4 null GS hostile", 3'd5, '0, 1'b0, 2'd3, 2'd3, 6'b100000, 2'd0, 3'd0);
  endtask

  task automatic t_types();
    load("R5 CS code", 3'd0, 13'd4, 1'b0, 2'd3, 2'd0, A_CODE_X, 2'd0, 3'd0);
    load("R5 CS data", 3'd0, 13'd4, 1'b0, 2'd0, 2'd0, A_DATA_RW, 2'd0, 3'd2);
    load("R6 DS sys", 3'd2, 13'd4, 1'b0, 2'd0, 2'd0, A_SYS, 2'd3, 3'd2);
    load("R6 ES exec-only", 3'd3, 13'd4, 1'b0, 2'd0, 2'd0, A_CODE_X, 2'd3, 3'd2);
    load("R6 FS readable code", 3'd4, 13'd4, 1'b0, 2'd0, 2'd0, A_CODE_R, 2'd3, 3'd0);
    load("R7 SS read-only", 3'd1, 13'd4, 1'b0, 2'd0, 2'd0, A_DATA_RO, 2'd0, 3'd2);
    load("R7 SS code", 3'd1, 13'd4, 1'b0, 2'd0, 2'd0, A_CODE_R, 2'd0, 3'd2);
    load("R12 reserved reg", 3'd6, 13'd4, 1'b0, 2'd0, 2'd0, A_DATA_RW, 2'd3, 3'd2);
  endtask

  task automatic t_priv();
    load("R2 rpl raises epl", 3'd2, 13'd9, 1'b0, 2'd3, 2'd0, A_DATA_RW, 2'd2, 3'd3);
    load("R2 cpl raises epl", 3'd2, 13'd9, 1'b0, 2'd0, 2'd3, A_DATA_RW, 2'd2, 3'd3);
    load("R2 epl equal dpl", 3'd2, 13'd9, 1'b0, 2'd1, 2'd2, A_DATA_RW, 2'd2, 3'd0);
    load("R8 dpl above epl", 3'd3, 13'd9, 1'b0, 2'd1, 2'd1, A_DATA_RO, 2'd3, 3'd0);
    load("R9 conforming skip", 3'd4, 13'd9, 1'b0, 2'd3, 2'd3, A_CODE_RC, 2'd0, 3'd0);
    load("R9 nonconf no skip", 3'd4, 13'd9, 1'b0, 2'd3, 2'd3, A_CODE_R, 2'd0, 3'd3);
    load("R10 SS ok", 3'd1, 13'd9, 1'b0, 2'd2, 2'd2, A_DATA_RW, 2'd2, 3'd0);
    load("R10 SS rpl mismatch", 3'd1, 13'd9, 1'b0, 2'd3, 2'd2, A_DATA_RW, 2'd2, 3'd3);
    load("R10 SS dpl mismatch", 3'd1, 13'd9, 1'b0, 2'd2, 2'd2, A_DATA_RW, 2'd3, 3'd3);
  endtask

  task automatic t_order();
    load("R11 not present", 3'd2, 13'd9, 1'b0, 2'd0, 2'd0, 6'b000100, 2'd0, 3'd4);
    load("R11 priv beats np", 3'd1, 13'd9, 1'b0, 2'd1, 2'd0, 6'b000100, 2'd0, 3'd3);
    load("R11 type beats priv", 3'd1, 13'd9, 1'b0, 2'd1, 2'd0, 6'b000000, 2'd3, 3'd2);
    load("R11 null beats type", 3'd0, '0, 1'b0, 2'd0, 2'd0, 6'b100000, 2'd0, 3'd1);
    load("R11 CS np", 3'd0, 13'd9, 1'b0, 2'd3, 2'd0, 6'b011000, 2'd0, 3'd4);
  endtask

  initial begin
    t_reset();
    t_null();
    t_types();
    t_priv();
    t_order();
    @(negedge clk);
    check("R1 drop after req", {2'b0, rsp_valid}, 3'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule